// File: doc/BRIEF.md
# Ethernet PHY Management Register Responder

This block models the management register space of an Ethernet PHY behind an MDIO slave front end. The front end decodes serial frames and presents each access as a parallel request: a 5-bit register number with either a write strobe and 16 bits of data, or a read strobe. The block holds thirty-two 16-bit registers that load fixed values at reset. It returns read data one clock after the read strobe.

Three register numbers do not return their stored contents. The basic status word, the link partner ability word and the diagnostic word are computed from a link-up input and from the stored advertisement word (register 4). The modelled partner always accepts every mode the station advertises. The duplex result of the diagnostic word is also driven on a dedicated output, so a MAC can compare it with its own duplex setting. Line coding, real negotiation signalling and analog behaviour are not modelled.

Top module: `mdio_phy_regfile`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, and register 4 (advertisement) reads 0x01E1. Every other stored register reads 0x0000, and rd_data is 0x0000.
- R2: A write stores wr_data into the register selected by reg_sel at the clock edge where wr_en is high. A later read of any register other than 1, 5 and 18 returns the stored value unchanged.
- R3: A read of register 1 returns 0x0000 while link_up is low. While link_up is high it returns 0x782C, which has bits 14, 13, 12, 11, 5, 3 and 2 set.
- R4: A read of register 5 returns 0x4001 OR (register 4 AND 0x01E0). Bits 8:5 are therefore copied from the advertisement word, and bits 14 and 0 are set.
- R5: A read of register 18 returns 0x0000 while link_up is low. Otherwise, bit 10 is register4[7] OR register4[8], bit 11 is register4[8] OR register4[6], and all other bits are zero. In register 4, bit 5 means 10 Mb/s half duplex, bit 6 means 10 full, bit 7 means 100 half and bit 8 means 100 full.
- R6: Writes to registers 1, 5 and 18 are accepted, but reads of those numbers still return the computed values of R3 to R5.
- R7: full_duplex equals link_up AND (register4[8] OR register4[6]). It follows a write to register 4 from the edge of that write.
- R8: The read result appears on rd_data at the clock edge where rd_en is high. It uses link_up and the register contents as they were just before that edge, so a read and a write to the same register in one cycle return the old contents.
- R9: rd_data holds its value in every cycle in which rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 5 | Register number for the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, registered |
| link_up | input | 1 | Link state of the modelled PHY |
| full_duplex | output | 1 | Duplex result of the diagnostic word |

## Verification
The bench targets the advertisement combinations that make the computed words diverge. Setting only bit 6 or only bit 7 in register 4 exposes a design that swaps the speed and duplex terms in register 18 or in full_duplex. A design that lets writes overwrite registers 1, 5 or 18 is caught because those numbers are written and then read back. A read and a write to the same register in one cycle are issued together, which catches a design that forwards the new data instead of returning the old. Link drops in the middle of a run must clear registers 1 and 18 and full_duplex, while register 5 stays unaffected.

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          link_up,
  output logic          full_duplex
);
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] R_CTRL = AW'(0);
  localparam logic [AW-1:0] R_STAT = AW'(1);
  localparam logic [AW-1:0] R_ID1  = AW'(2);
  localparam logic [AW-1:0] R_ID2  = AW'(3);
  localparam logic [AW-1:0] R_ADV  = AW'(4);
  localparam logic [AW-1:0] R_LPA  = AW'(5);
  localparam logic [AW-1:0] R_DIAG = AW'(18);
  localparam logic [DW-1:0] STAT_UP = DW'(16'h782C);
  localparam logic [DW-1:0] LPA_FIX = DW'(16'h4001);
  localparam logic [DW-1:0] LPA_MSK = DW'(16'h01E0);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] adv;
  logic          spd100;
  logic [DW-1:0] rd_next;

  assign adv         = regs[R_ADV];
  assign spd100      = adv[7] | adv[8];
  assign full_duplex = link_up & (adv[8] | adv[6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[R_CTRL] <= DW'(16'h3100);
      regs[R_ID1]  <= DW'(16'h0300);
      regs[R_ID2]  <= DW'(16'hE400);
      regs[R_ADV]  <= DW'(16'h01E1);
    end else if (wr_en) begin
      regs[reg_sel] <= wr_data;
    end
  end

  always_comb begin
    rd_next = regs[reg_sel];
    case (reg_sel)
      R_STAT: rd_next = link_up ? STAT_UP : '0;
      R_LPA:  rd_next = LPA_FIX | (adv & LPA_MSK);
      R_DIAG: begin
        rd_next = '0;
        rd_next[10] = link_up & spd100;
        rd_next[11] = full_duplex;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/mdio_phy_regfile_chk.sv
module mdio_phy_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_sel,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        link_up,
  input logic        full_duplex
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_stat_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 5'd1 && link_up) |=> rd_data == 16'h782C);
  p_stat_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 5'd1 && !link_up) |=> rd_data == 16'h0000);
  p_lpa_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 5'd5) |=> (rd_data[15:9] == 7'h20 && rd_data[4:0] == 5'h01));
  p_diag_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 5'd18 && !link_up) |=> rd_data == 16'h0000);
  p_fd_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !full_duplex);
  p_diag_fd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 5'd18) |=> rd_data[11] == $past(full_duplex));
endmodule

bind mdio_phy_regfile mdio_phy_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
  .rd_data(rd_data), .link_up(link_up), .full_duplex(full_duplex)
);

// File: tb/mdio_phy_regfile_test.sv
module mdio_phy_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  reg_sel = '0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 0;
  logic [15:0] rd_data;
  logic        link_up = 1;
  logic        full_duplex;

  int total = 0;
  int bad = 0;
  logic [15:0] m [32];

  always #5ns clk = ~clk;

  mdio_phy_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .link_up(link_up), .full_duplex(full_duplex)
  );

  function automatic logic [15:0] exp_rd(int sel, logic lk);
    logic [15:0] a, r;
    a = m[4];
    case (sel)
      1:  r = lk ? 16'h782C : 16'h0000;
      5:  r = 16'h4001 | (a & 16'h01E0);
      18: begin
        r = '0;
        if (lk) begin
          r[10] = a[7] | a[8];
          r[11] = a[8] | a[6];
        end
      end
      default: r = m[sel];
    endcase
    return r;
  endfunction

  function automatic logic exp_fd(logic lk);
    return lk & (m[4][8] | m[4][6]);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_read(string req, int sel);
    logic [15:0] e;
    @(negedge clk);
    reg_sel = 5'(sel); rd_en = 1;
    e = exp_rd(sel, link_up);
    @(negedge clk);
    rd_en = 0;
    check(req, rd_data, e);
  endtask

  task automatic do_write(int sel, logic [15:0] d);
    @(negedge clk);
    reg_sel = 5'(sel); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    m[sel] = d;
  endtask

  task automatic check_fd(string req);
    #1ns;
    check(req, {15'd0, full_duplex}, {15'd0, exp_fd(link_up)});
  endtask

  initial begin
    #2ms;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held, e;
    int unused;
    unused = $urandom(32'd4711);
    for (int i = 0; i < 32; i++) m[i] = '0;
    m[0] = 16'h3100; m[2] = 16'h0300; m[3] = 16'hE400; m[4] = 16'h01E1;
    repeat (3) @(negedge clk);
    check("R1 rd_data reset", rd_data, 16'h0000);
    rst_n = 1;
    for (int i = 0; i < 32; i++)
      if (i != 1 && i != 5 && i != 18) do_read("R1 reset value", i);

    do_read("R3 status link up", 1);
    link_up = 0;
    check_fd("R7 fd link down");
    do_read("R3 status link down", 1);
    do_read("R5 diag link down", 18);
    do_read("R4 partner with link down", 5);
    link_up = 1;
    check_fd("R7 fd default adv");

    do_write(4, 16'h0040);
    check_fd("R7 fd 10 full only");
    do_read("R5 diag 10 full only", 18);
    do_read("R4 partner 10 full only", 5);
    do_write(4, 16'h0080);
    check_fd("R7 fd 100 half only");
    do_read("R5 diag 100 half only", 18);
    do_write(4, 16'hFE1F);
    check_fd("R7 fd no modes");
    do_read("R4 partner no modes", 5);
    do_read("R5 diag no modes", 18);

    do_write(1, 16'h0000);
    do_read("R6 status ignores store", 1);
    do_write(5, 16'hFFFF);
    do_read("R6 partner ignores store", 5);
    do_write(18, 16'hFFFF);
    do_read("R6 diag ignores store", 18);
    do_write(31, 16'hA5C3);
    do_read("R2 top register", 31);

    @(negedge clk);
    reg_sel = 5'd7; wr_data = 16'h1234; wr_en = 1; rd_en = 1;
    e = m[7];
    @(negedge clk);
    wr_en = 0; rd_en = 0; m[7] = 16'h1234;
    check("R8 same cycle old value", rd_data, e);
    do_read("R8 new value after", 7);

    held = rd_data;
    do_write(7, 16'hBEEF);
    link_up = 0;
    repeat (3) @(negedge clk);
    check("R9 hold without read", rd_data, held);
    link_up = 1;

    for (int n = 0; n < 400; n++) begin
      int op, sel;
      op = int'($urandom % 4);
      sel = int'($urandom % 32);
      if ($urandom % 4 == 0) sel = 4;
      case (op)
        0: do_write(sel, 16'($urandom));
        1: do_read("R2 random read", sel);
        2: do_read("R5 random diag", ($urandom % 2) ? 18 : 5);
        default: begin
          @(negedge clk);
          link_up = 1'($urandom);
          check_fd("R7 random link");
          do_read("R3 random status", 1);
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule